// File: doc/BRIEF.md
# CEC message buffer command controller

This block sits between a host register port and a bit-level CEC line engine. It holds one 16-byte transmit message and one 16-byte receive message in a byte-addressed register space. Software fills the transmit bytes, writes the length as byte count minus one, and issues a two-bit command. The block then hands the message to the line engine, which fetches the bytes by index and reports completion. Received frames arrive from the line engine byte by byte and are closed with an end strobe, a length and an error flag. The host reads the frame back, acknowledges it with a two-bit receive command, and polls two-bit status codes for both directions.

A logical address register gates reception. Transmit and receive completion events set pending interrupt bits, which a mask register enables onto a single interrupt line and a clear register removes. Each buffer has a clear control that holds it empty for as long as it is set. Bit timing and arbitration on the wire are handled elsewhere.

Top module: `cec_msgbuf_ctrl`

## Requirements
- R1: After reset, transmit status (0x93), receive status (0x91) and the received message count (0x92) read 0, `irq` is low, and every buffer byte reads 0.
- R2: Host writes to 0x00–0x0F store transmit bytes, header at 0x00 and opcode at 0x01, and a write to 0x10 stores the length as byte count minus one. Each reads back one cycle after its address is presented, and bytes never written read 0.
- R3: Writing transmit command 1 (send) or 3 (replace and send next) to 0x11 while a message is pending moves transmit status to 1 (busy) and raises `tx_start` for one cycle. The line engine then sees the length on `tx_len` and reads byte k on `tx_rd_byte` one cycle after it puts k on `tx_rd_idx`. Writing the length register marks a message pending, and starting the transfer clears that mark.
- R4: A send command with no message pending leaves transmit status at 0 and does not raise `tx_start`.
- R5: While busy, a `tx_done` pulse sets transmit status to 2 (done) when `tx_err` is low or 3 (error) when it is high, and sets interrupt pending bit 1.
- R6: Writing command 0 (no operation) while transmit status is 2 or 3 returns it to 0.
- R7: Command 2 (abort) while busy returns transmit status to 0 and raises `tx_abort` for one cycle. A later `tx_done` is then ignored and sets no interrupt.
- R8: A frame is stored only while bit 4 of the logical address register (0x16) is set; bits 3:0 hold the address and drive `own_addr`. An error-free accepted frame gives receive status 2, count 1, length at 0x90, bytes at 0x80–0x8F, and interrupt pending bit 2. An accepted frame that ends with `rx_err` high gives status 3 and count 0.
- R9: A frame that ends while the count is already 1 is dropped: the stored bytes and length are unchanged and receive status becomes 3.
- R10: Receive command 1 (acknowledge) or 3 (release and read next) written to 0x14 sets the count and receive status to 0. While the receive command register holds 2 (disable), incoming frames are ignored.
- R11: Interrupt registers use bit 1 for transmit and bit 2 for receive: mask at 0xA0 (1 enables), clear at 0xA1 (writing 1 clears the pending bit), pending status at 0xA2. `irq` is high one cycle after any pending bit is set with its mask bit set.
- R12: Writing 1 to 0x13 (transmit) or 0x15 (receive) holds that buffer cleared: its bytes read 0, writes to it are ignored, its length reads 0, its status returns to 0 and its pending message or count is dropped. Writing 0 releases it, and the bytes still read 0 until they are written again.
- R13: While transmit status is busy, host writes to the transmit bytes and the length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 8 | Host byte address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data for the address presented one cycle earlier |
| irq | output | 1 | Combined masked interrupt |
| own_addr | output | 4 | Programmed logical address |
| own_addr_en | output | 1 | Logical address valid flag |
| tx_start | output | 1 | One-cycle request to send the buffered message |
| tx_abort | output | 1 | One-cycle request to abandon the current send |
| tx_len | output | 4 | Message length minus one |
| tx_rd_idx | input | 4 | Line-side transmit byte index |
| tx_rd_byte | output | 8 | Transmit byte at the index from the previous cycle |
| tx_done | input | 1 | Send finished |
| tx_err | input | 1 | Send finished with error, qualified by tx_done |
| rx_wr | input | 1 | Received byte strobe |
| rx_wr_idx | input | 4 | Received byte index |
| rx_wr_byte | input | 8 | Received byte |
| rx_end | input | 1 | Frame finished |
| rx_err | input | 1 | Frame finished with error, qualified by rx_end |
| rx_len | input | 4 | Frame length minus one, qualified by rx_end |

## Verification
A wrong status state shows at the host status registers on the next read, since each code is registered one cycle after the triggering write or line pulse. It also shows within the same cycle on `tx_start` or `tx_abort`, which must agree with the busy or idle code. A wrong buffer-full flag or gate shows as a dropped or overwritten frame: the stored bytes at 0x80 onward differ from the first frame, or the status reads 2 where 3 is due. A stale pending or mask bit shows on `irq` exactly one cycle after the event or clear, and that cycle is where the bench samples.

// File: rtl/cec_mb_pkg.sv
package cec_mb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } xfer_st_e;

  // transmit command codes
  localparam logic [1:0] TXC_NOP   = 2'd0;
  localparam logic [1:0] TXC_SEND  = 2'd1;
  localparam logic [1:0] TXC_ABORT = 2'd2;
  localparam logic [1:0] TXC_NEXT  = 2'd3;

  // receive command codes
  localparam logic [1:0] RXC_NOP  = 2'd0;
  localparam logic [1:0] RXC_ACK  = 2'd1;
  localparam logic [1:0] RXC_OFF  = 2'd2;
  localparam logic [1:0] RXC_NEXT = 2'd3;

  // register addresses
  localparam logic [7:0] RX_BASE = 8'h80;
  localparam logic [7:0] A_TXLEN = 8'h10;
  localparam logic [7:0] A_TXCMD = 8'h11;
  localparam logic [7:0] A_TXCLR = 8'h13;
  localparam logic [7:0] A_RXCMD = 8'h14;
  localparam logic [7:0] A_RXCLR = 8'h15;
  localparam logic [7:0] A_LADDR = 8'h16;
  localparam logic [7:0] A_RXLEN = 8'h90;
  localparam logic [7:0] A_RXST  = 8'h91;
  localparam logic [7:0] A_RXCNT = 8'h92;
  localparam logic [7:0] A_TXST  = 8'h93;
  localparam logic [7:0] A_IMASK = 8'hA0;
  localparam logic [7:0] A_ICLR  = 8'hA1;
  localparam logic [7:0] A_ISTAT = 8'hA2;

  // interrupt bit positions
  localparam int INT_TX = 1;
  localparam int INT_RX = 2;

endpackage

// File: rtl/cec_msg_store.sv
module cec_msg_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    ra_q, rb_q;
  logic             ra_v_q, rb_v_q;

  // storage array: no reset, registered reads
  always_ff @(posedge clk) begin
    if (we_i && !clr_i) mem[waddr_i] <= wdata_i;
    ra_q <= mem[ra_addr_i];
    rb_q <= mem[rb_addr_i];
  end

  // per-byte written flags, dropped while the buffer is held clear
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      vld_q <= '0;
    end else if (we_i) begin
      vld_q[waddr_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_v_q <= 1'b0;
      rb_v_q <= 1'b0;
    end else begin
      ra_v_q <= vld_q[ra_addr_i] && !clr_i;
      rb_v_q <= vld_q[rb_addr_i] && !clr_i;
    end
  end

  assign ra_data_o = ra_q & {DW{ra_v_q}};
  assign rb_data_o = rb_q & {DW{rb_v_q}};

  // R12
  store_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (vld_q == '0));

endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
  import cec_mb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_we_i,
  input  logic [1:0] cmd_i,
  input  logic       len_we_i,
  input  logic       clr_i,
  input  logic       done_i,
  input  logic       err_i,
  output xfer_st_e   st_o,
  output logic       start_o,
  output logic       abort_o,
  output logic       evt_o
);

  xfer_st_e st_q;
  logic     pend_q;
  logic     send_req, abort_req, nop_req;

  assign send_req  = cmd_we_i && (cmd_i == TXC_SEND || cmd_i == TXC_NEXT);
  assign abort_req = cmd_we_i && (cmd_i == TXC_ABORT);
  assign nop_req   = cmd_we_i && (cmd_i == TXC_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      pend_q  <= 1'b0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
      if (clr_i) begin
        if (st_q == ST_BUSY) abort_o <= 1'b1;
        st_q   <= ST_IDLE;
        pend_q <= 1'b0;
      end else if (st_q == ST_BUSY) begin
        if (abort_req) begin
          st_q    <= ST_IDLE;
          abort_o <= 1'b1;
        end else if (done_i) begin
          st_q <= err_i ? ST_ERR : ST_DONE;
        end
      end else begin
        if (len_we_i) pend_q <= 1'b1;
        if (send_req && pend_q) begin
          st_q    <= ST_BUSY;
          start_o <= 1'b1;
          pend_q  <= 1'b0;
        end else if (nop_req && (st_q == ST_DONE || st_q == ST_ERR)) begin
          st_q <= ST_IDLE;
        end
      end
    end
  end

  assign st_o  = st_q;
  assign evt_o = (st_q == ST_BUSY) && done_i && !clr_i && !abort_req;

  // R3
  tx_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (st_q == ST_BUSY));

  // R5
  tx_finish_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_q != $past(st_q)) && (st_q == ST_DONE || st_q == ST_ERR))
      |-> ($past(st_q) == ST_BUSY));

  // R7
  tx_abort_chk: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (st_q == ST_IDLE));

endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_mb_pkg::*;
#(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we_i,
  input  logic [1:0]    cmd_i,
  input  logic          clr_i,
  input  logic          addr_ok_i,
  input  logic          byte_we_i,
  input  logic          msg_end_i,
  input  logic          msg_err_i,
  input  logic [LW-1:0] msg_len_i,
  output xfer_st_e      st_o,
  output logic [1:0]    cmd_o,
  output logic          full_o,
  output logic [LW-1:0] len_o,
  output logic          accept_o,
  output logic          evt_o
);

  xfer_st_e      st_q;
  logic          full_q;
  logic [LW-1:0] len_q;
  logic [1:0]    cmd_q;
  logic          listen, release_req;

  assign listen      = addr_ok_i && (cmd_q != RXC_OFF) && !clr_i;
  assign accept_o    = listen && !full_q;
  assign release_req = cmd_we_i && (cmd_i == RXC_ACK || cmd_i == RXC_NEXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      full_q <= 1'b0;
      len_q  <= '0;
      cmd_q  <= RXC_NOP;
    end else begin
      if (cmd_we_i) cmd_q <= cmd_i;
      if (clr_i) begin
        st_q   <= ST_IDLE;
        full_q <= 1'b0;
        len_q  <= '0;
      end else if (release_req) begin
        st_q   <= ST_IDLE;
        full_q <= 1'b0;
      end else if (msg_end_i && listen) begin
        if (full_q || msg_err_i) begin
          st_q <= ST_ERR;
        end else begin
          st_q   <= ST_DONE;
          full_q <= 1'b1;
          len_q  <= msg_len_i;
        end
      end else if (byte_we_i && accept_o && st_q != ST_BUSY) begin
        st_q <= ST_BUSY;
      end
    end
  end

  assign st_o   = st_q;
  assign cmd_o  = cmd_q;
  assign full_o = full_q;
  assign len_o  = len_q;
  assign evt_o  = msg_end_i && listen && !release_req;

  // R9
  rx_full_status_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (st_q == ST_DONE || st_q == ST_ERR));

  // R8
  rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_end_i && !addr_ok_i && !cmd_we_i && !clr_i) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/cec_irq_ctrl.sv
module cec_irq_ctrl #(
  parameter int          W    = 8,
  parameter logic [W-1:0] IMPL = 8'b0000_0110
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);

  logic [W-1:0] mask_q, pend_q, clr_vec;

  assign clr_vec = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & IMPL;
      pend_q <= ((pend_q & ~clr_vec) | set_i) & IMPL;
      irq_o  <= |(pend_q & mask_q);
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && wdata_i[1] && !set_i[1]) |=> !pend_q[1]);

endmodule

// File: rtl/cec_msgbuf_ctrl.sv
module cec_msgbuf_ctrl
  import cec_mb_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int DW        = 8,
  parameter int AW        = 8,
  localparam int IW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic [3:0]    own_addr,
  output logic          own_addr_en,
  output logic          tx_start,
  output logic          tx_abort,
  output logic [IW-1:0] tx_len,
  input  logic [IW-1:0] tx_rd_idx,
  output logic [DW-1:0] tx_rd_byte,
  input  logic          tx_done,
  input  logic          tx_err,
  input  logic          rx_wr,
  input  logic [IW-1:0] rx_wr_idx,
  input  logic [DW-1:0] rx_wr_byte,
  input  logic          rx_end,
  input  logic          rx_err,
  input  logic [IW-1:0] rx_len
);

  localparam logic [AW-IW-1:0] RX_PAGE = RX_BASE[AW-1:IW];

  logic          tx_region, rx_region;
  logic          tx_region_q, rx_region_q;
  logic          tx_clr_q, rx_clr_q;
  logic [4:0]    laddr_q;
  logic [1:0]    tx_cmd_q;
  logic [IW-1:0] tx_len_q;
  logic [DW-1:0] misc_d, misc_q;
  logic [DW-1:0] tx_host_rd, rx_host_rd, rx_rb_unused;
  logic [DW-1:0] irq_set, irq_mask, irq_pend;
  logic          tx_busy, tx_buf_we, rx_buf_we;
  logic          tx_evt, rx_evt, rx_accept, rx_full;
  logic [1:0]    rx_cmd;
  logic [IW-1:0] rx_len_q;
  xfer_st_e      tx_st, rx_st;

  assign tx_region = (reg_addr[AW-1:IW] == '0);
  assign rx_region = (reg_addr[AW-1:IW] == RX_PAGE);
  assign tx_busy   = (tx_st == ST_BUSY);
  assign tx_buf_we = reg_we && tx_region && !tx_busy;
  assign rx_buf_we = rx_wr && rx_accept;

  // host-controlled registers
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_clr_q <= 1'b0;
      rx_clr_q <= 1'b0;
      laddr_q  <= '0;
      tx_cmd_q <= TXC_NOP;
      tx_len_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_TXCLR) tx_clr_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_RXCLR) rx_clr_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_LADDR) laddr_q  <= reg_wdata[4:0];
      if (reg_we && reg_addr == A_TXCMD) tx_cmd_q <= reg_wdata[1:0];
      if (tx_clr_q) begin
        tx_len_q <= '0;
      end else if (reg_we && reg_addr == A_TXLEN && !tx_busy) begin
        tx_len_q <= reg_wdata[IW-1:0];
      end
    end
  end

  cec_msg_store #(.DEPTH(BUF_DEPTH), .DW(DW)) u_tx_store (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (tx_clr_q),
    .we_i      (tx_buf_we),
    .waddr_i   (reg_addr[IW-1:0]),
    .wdata_i   (reg_wdata),
    .ra_addr_i (reg_addr[IW-1:0]),
    .ra_data_o (tx_host_rd),
    .rb_addr_i (tx_rd_idx),
    .rb_data_o (tx_rd_byte)
  );

  cec_msg_store #(.DEPTH(BUF_DEPTH), .DW(DW)) u_rx_store (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (rx_clr_q),
    .we_i      (rx_buf_we),
    .waddr_i   (rx_wr_idx),
    .wdata_i   (rx_wr_byte),
    .ra_addr_i (reg_addr[IW-1:0]),
    .ra_data_o (rx_host_rd),
    .rb_addr_i ('0),
    .rb_data_o (rx_rb_unused)
  );

  cec_tx_ctrl u_tx_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd_we_i (reg_we && reg_addr == A_TXCMD),
    .cmd_i    (reg_wdata[1:0]),
    .len_we_i (reg_we && reg_addr == A_TXLEN),
    .clr_i    (tx_clr_q),
    .done_i   (tx_done),
    .err_i    (tx_err),
    .st_o     (tx_st),
    .start_o  (tx_start),
    .abort_o  (tx_abort),
    .evt_o    (tx_evt)
  );

  cec_rx_ctrl #(.LW(IW)) u_rx_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_we_i  (reg_we && reg_addr == A_RXCMD),
    .cmd_i     (reg_wdata[1:0]),
    .clr_i     (rx_clr_q),
    .addr_ok_i (laddr_q[4]),
    .byte_we_i (rx_wr),
    .msg_end_i (rx_end),
    .msg_err_i (rx_err),
    .msg_len_i (rx_len),
    .st_o      (rx_st),
    .cmd_o     (rx_cmd),
    .full_o    (rx_full),
    .len_o     (rx_len_q),
    .accept_o  (rx_accept),
    .evt_o     (rx_evt)
  );

  always_comb begin
    irq_set         = '0;
    irq_set[INT_TX] = tx_evt;
    irq_set[INT_RX] = rx_evt;
  end

  cec_irq_ctrl #(.W(DW)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .mask_we_i (reg_we && reg_addr == A_IMASK),
    .clr_we_i  (reg_we && reg_addr == A_ICLR),
    .wdata_i   (reg_wdata),
    .set_i     (irq_set),
    .mask_o    (irq_mask),
    .pend_o    (irq_pend),
    .irq_o     (irq)
  );

  // read path for the non-buffer registers
  always_comb begin
    misc_d = '0;
    case (reg_addr)
      A_TXLEN: misc_d[IW-1:0] = tx_len_q;
      A_TXCMD: misc_d[1:0]    = tx_cmd_q;
      A_TXCLR: misc_d[0]      = tx_clr_q;
      A_RXCMD: misc_d[1:0]    = rx_cmd;
      A_RXCLR: misc_d[0]      = rx_clr_q;
      A_LADDR: misc_d[4:0]    = laddr_q;
      A_RXLEN: misc_d[IW-1:0] = rx_len_q;
      A_RXST:  misc_d[1:0]    = rx_st;
      A_RXCNT: misc_d[0]      = rx_full;
      A_TXST:  misc_d[1:0]    = tx_st;
      A_IMASK: misc_d         = irq_mask;
      A_ISTAT: misc_d         = irq_pend;
      default: misc_d         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q      <= '0;
      tx_region_q <= 1'b0;
      rx_region_q <= 1'b0;
    end else begin
      misc_q      <= misc_d;
      tx_region_q <= tx_region;
      rx_region_q <= rx_region;
    end
  end

  assign reg_rdata   = tx_region_q ? tx_host_rd :
                       rx_region_q ? rx_host_rd : misc_q;
  assign tx_len      = tx_len_q;
  assign own_addr    = laddr_q[3:0];
  assign own_addr_en = laddr_q[4];

  // R13
  tx_len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !tx_clr_q) |=> (tx_len_q == $past(tx_len_q)));

endmodule

// File: tb/test_cec_msgbuf_ctrl.sv
`timescale 1ns/1ps
module test_cec_msgbuf_ctrl;
  import cec_mb_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  logic [3:0] own_addr;
  logic       own_addr_en;
  logic       tx_start, tx_abort;
  logic [3:0] tx_len;
  logic [3:0] tx_rd_idx = '0;
  logic [7:0] tx_rd_byte;
  logic       tx_done = 1'b0, tx_err = 1'b0;
  logic       rx_wr = 1'b0;
  logic [3:0] rx_wr_idx = '0;
  logic [7:0] rx_wr_byte = '0;
  logic       rx_end = 1'b0, rx_err = 1'b0;
  logic [3:0] rx_len = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cec_msgbuf_ctrl i_cec_msgbuf_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .own_addr(own_addr), .own_addr_en(own_addr_en),
    .tx_start(tx_start), .tx_abort(tx_abort), .tx_len(tx_len),
    .tx_rd_idx(tx_rd_idx), .tx_rd_byte(tx_rd_byte),
    .tx_done(tx_done), .tx_err(tx_err),
    .rx_wr(rx_wr), .rx_wr_idx(rx_wr_idx), .rx_wr_byte(rx_wr_byte),
    .rx_end(rx_end), .rx_err(rx_err), .rx_len(rx_len)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic line_done(input logic e);
    @(negedge clk);
    tx_done = 1'b1; tx_err = e;
    @(negedge clk);
    tx_done = 1'b0; tx_err = 1'b0;
  endtask

  task automatic line_rx(input logic [7:0] b0, input logic [7:0] b1, input logic e);
    @(negedge clk);
    rx_wr = 1'b1; rx_wr_idx = 4'd0; rx_wr_byte = b0;
    @(negedge clk);
    rx_wr_idx = 4'd1; rx_wr_byte = b1;
    @(negedge clk);
    rx_wr = 1'b0; rx_end = 1'b1; rx_err = e; rx_len = 4'd1;
    @(negedge clk);
    rx_end = 1'b0; rx_err = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 tx status", A_TXST, 8'h00);
    rd_chk("R1 rx status", A_RXST, 8'h00);
    rd_chk("R1 rx count", A_RXCNT, 8'h00);
    rd_chk("R1 tx byte 0", 8'h00, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tx_nopend;
    wr(A_TXCMD, 8'h01);
    chk("R4 no start", {7'b0, tx_start}, 8'h00);
    rd_chk("R4 status stays idle", A_TXST, 8'h00);
    wr(A_TXCMD, 8'h00);
  endtask

  task automatic t_buf_rw;
    wr(8'h00, 8'h4F);
    wr(8'h01, 8'h36);
    wr(8'h02, 8'hA5);
    wr(8'h03, 8'h11);
    wr(A_TXLEN, 8'h03);
    rd_chk("R2 header", 8'h00, 8'h4F);
    rd_chk("R2 byte 2", 8'h02, 8'hA5);
    rd_chk("R2 length", A_TXLEN, 8'h03);
    rd_chk("R2 unwritten byte", 8'h0F, 8'h00);
  endtask

  task automatic t_tx_send;
    wr(A_TXCMD, 8'h01);
    chk("R3 start pulse", {7'b0, tx_start}, 8'h01);
    rd_chk("R3 status busy", A_TXST, 8'h01);
    chk("R3 line length", {4'b0, tx_len}, 8'h03);
    @(negedge clk); tx_rd_idx = 4'd2;
    @(negedge clk);
    chk("R3 line byte 2", tx_rd_byte, 8'hA5);
    wr(8'h02, 8'h00);
    wr(A_TXLEN, 8'h07);
    rd_chk("R13 byte kept while busy", 8'h02, 8'hA5);
    rd_chk("R13 length kept while busy", A_TXLEN, 8'h03);
    line_done(1'b0);
    rd_chk("R5 status done", A_TXST, 8'h02);
    rd_chk("R5 tx pending bit", A_ISTAT, 8'h02);
    chk("R11 masked irq low", {7'b0, irq}, 8'h00);
    wr(A_TXCMD, 8'h00);
    rd_chk("R6 nop returns idle", A_TXST, 8'h00);
    wr(A_ICLR, 8'h02);
  endtask

  task automatic t_tx_err_abort;
    wr(A_IMASK, 8'h06);
    wr(A_TXLEN, 8'h03);
    wr(A_TXCMD, 8'h01);
    line_done(1'b1);
    rd_chk("R5 status error", A_TXST, 8'h03);
    chk("R11 irq raised", {7'b0, irq}, 8'h01);
    wr(A_ICLR, 8'h02);
    @(negedge clk);
    chk("R11 irq cleared", {7'b0, irq}, 8'h00);
    rd_chk("R11 pending cleared", A_ISTAT, 8'h00);
    wr(A_TXCMD, 8'h00);
    rd_chk("R6 nop after error", A_TXST, 8'h00);
    wr(A_TXLEN, 8'h03);
    wr(A_TXCMD, 8'h01);
    wr(A_TXCMD, 8'h02);
    chk("R7 abort pulse", {7'b0, tx_abort}, 8'h01);
    rd_chk("R7 status idle", A_TXST, 8'h00);
    line_done(1'b0);
    rd_chk("R7 late done ignored", A_TXST, 8'h00);
    rd_chk("R7 no interrupt", A_ISTAT, 8'h00);
    wr(A_TXCMD, 8'h00);
  endtask

  task automatic t_rx;
    wr(A_LADDR, 8'h04);
    line_rx(8'h40, 8'h8F, 1'b0);
    rd_chk("R8 invalid address status", A_RXST, 8'h00);
    rd_chk("R8 invalid address count", A_RXCNT, 8'h00);
    wr(A_LADDR, 8'h14);
    chk("R8 own address", {3'b0, own_addr_en, own_addr}, 8'h14);
    line_rx(8'h40, 8'h8F, 1'b0);
    rd_chk("R8 status done", A_RXST, 8'h02);
    rd_chk("R8 count", A_RXCNT, 8'h01);
    rd_chk("R8 length", A_RXLEN, 8'h01);
    rd_chk("R8 header", 8'h80, 8'h40);
    rd_chk("R8 byte 1", 8'h81, 8'h8F);
    rd_chk("R8 rx pending bit", A_ISTAT, 8'h04);
    chk("R11 rx irq", {7'b0, irq}, 8'h01);
    wr(A_ICLR, 8'h04);
    line_rx(8'h41, 8'h22, 1'b0);
    rd_chk("R9 status error", A_RXST, 8'h03);
    rd_chk("R9 count kept", A_RXCNT, 8'h01);
    rd_chk("R9 byte kept", 8'h81, 8'h8F);
    rd_chk("R9 header kept", 8'h80, 8'h40);
    wr(A_ICLR, 8'h04);
    wr(A_RXCMD, 8'h01);
    rd_chk("R10 ack count", A_RXCNT, 8'h00);
    rd_chk("R10 ack status", A_RXST, 8'h00);
    wr(A_RXCMD, 8'h02);
    line_rx(8'h40, 8'h33, 1'b0);
    rd_chk("R10 disabled status", A_RXST, 8'h00);
    rd_chk("R10 disabled count", A_RXCNT, 8'h00);
    wr(A_RXCMD, 8'h00);
    line_rx(8'h40, 8'h33, 1'b1);
    rd_chk("R8 line error status", A_RXST, 8'h03);
    rd_chk("R8 line error count", A_RXCNT, 8'h00);
    wr(A_RXCMD, 8'h03);
    rd_chk("R10 next cmd status", A_RXST, 8'h00);
    wr(A_RXCMD, 8'h00);
    wr(A_ICLR, 8'h06);
  endtask

  task automatic t_clear;
    line_rx(8'h40, 8'h55, 1'b0);
    rd_chk("R12 rx filled", A_RXCNT, 8'h01);
    wr(A_RXCLR, 8'h01);
    rd_chk("R12 rx count dropped", A_RXCNT, 8'h00);
    rd_chk("R12 rx status idle", A_RXST, 8'h00);
    rd_chk("R12 rx length zero", A_RXLEN, 8'h00);
    rd_chk("R12 rx byte reads zero", 8'h80, 8'h00);
    wr(A_RXCLR, 8'h00);
    rd_chk("R12 rx byte after release", 8'h81, 8'h00);
    wr(8'h05, 8'h77);
    rd_chk("R12 tx byte before clear", 8'h05, 8'h77);
    wr(A_TXCLR, 8'h01);
    rd_chk("R12 tx byte held clear", 8'h05, 8'h00);
    wr(8'h05, 8'h12);
    wr(A_TXLEN, 8'h02);
    rd_chk("R12 tx write ignored", 8'h05, 8'h00);
    rd_chk("R12 tx length ignored", A_TXLEN, 8'h00);
    wr(A_TXCLR, 8'h00);
    rd_chk("R12 tx byte after release", 8'h05, 8'h00);
    wr(A_TXCMD, 8'h01);
    chk("R12 no pending after clear", {7'b0, tx_start}, 8'h00);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tx_nopend();
    t_buf_rw();
    t_tx_send();
    t_tx_err_abort();
    t_rx();
    t_clear();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule